// File: doc/BRIEF.md
# Sticky Fault Status Capture Register

This block records memory and bus error events for trap handlers. Bus and cache ECC checkers send it one-cycle event pulses. Each pulse carries:
- an event type (0 to 18),
- a physical address,
- a 9-bit data syndrome and a 4-bit tag syndrome,
- a transaction tag with a 16-byte subunit index,
- the privilege level in force when the error was detected.

Each event type owns one sticky flag in a 64-bit status word. Software clears a flag by writing 1 to it. Next to the flags the word holds a repeat-error flag, a captured privilege bit and two read-only syndrome fields.

A single fault address register and the two syndrome fields are shared by all event types. Each of them is held by the highest-priority event seen so far and is locked to that event. The lock is released only when that event's own flag is cleared. The captured value is kept after release, so a later event may overwrite it. A level interrupt output is raised while interrupts are enabled and any flag of the interrupting class is set.

Top module: `fault_status_reg`

## Requirements
- R1: An event with valid high and type t in 0..18 that is not dropped sets status bit 33+t at the next clock edge. Flags accumulate until they are cleared. Types 19 to 31 have no effect on any state.
- R2: Reading never changes state. A write with select 0 clears each of status bits 51:33, 52 and 53 that has a 1 in the write data, and leaves bits written 0 unchanged. Writes with select 1 are ignored, and so are writes to every other status bit, including both syndrome fields.
- R3: When an event sets a flag in the same cycle that a write clears that flag, the flag ends up set.
- R4: Bit 53 is set when an uncorrectable or software-correctable event arrives while its own flag is already set. Repeats of hardware-corrected types never set it. The classes are: hardware-corrected types 0, 3, 5, 7, 13 and 15; software-correctable type 9; every other type is uncorrectable.
- R5: Bit 52 takes the privilege input on every logged event. Otherwise it holds until it is cleared by a write.
- R6: The data-ECC types are 0 to 9, 12 and 13. For these types, the block remembers the tag and subunit of the last one it logged. A later data-ECC event with the same tag and a larger subunit index is dropped entirely: no flag, no bit 53, no bit 52 update and no capture. An event with a subunit index equal to or smaller than the remembered one starts a new transaction.
- R7: Read with select 1, the fault address register returns the captured address zero-extended to 64 bits. When the register is unlocked, any logged event loads it and locks it. While it is locked, only an event of strictly higher priority overwrites it. The priority order is uncorrectable (highest), then software-correctable, then hardware-corrected.
- R8: The lock is released as soon as the flag of the locking event is cleared, even if other flags stay set. The captured value is kept.
- R9: The data syndrome (status bits 8:0) captures only on data-ECC types. The tag syndrome (status bits 19:16) captures only on types 14 and 15. Each field follows the R7 and R8 rules on its own, independently of the other field and of the address register.
- R10: The interrupt output is high exactly while the interrupt enable is high and at least one of flags 0, 3, 5, 7, 13 or 15 is set.
- R11: After reset every flag, capture field and lock is zero, reads return 0, and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_vld_i | input | 1 | Error event pulse |
| evt_type_i | input | 5 | Event type |
| evt_addr_i | input | ADDR_W | Physical address of the fault |
| evt_dsyn_i | input | 9 | Data ECC syndrome |
| evt_tsyn_i | input | 4 | Tag ECC syndrome |
| evt_txn_i | input | TXN_W | Transaction tag |
| evt_sub_i | input | 2 | 16-byte subunit index within the 64-byte transaction |
| evt_priv_i | input | 1 | Privilege level at detection |
| reg_sel_i | input | 1 | Register select: 0 = status word, 1 = fault address |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | 64 | Write data (1 = clear) |
| reg_rdata_o | output | 64 | Read data of the selected register |
| irq_en_i | input | 1 | Interrupt enable |
| irq_o | output | 1 | Disrupting interrupt |

## Verification
Two paths can act in the same cycle: event logging, and the software write-1-to-clear. They collide when an event sets a flag that is being cleared. They also collide when a clear releases a lock in the same edge that a new event competes for the capture. The bench provokes both collisions with directed steps, and then with a long pseudo-random stream in which events and clear writes overlap freely. Every cycle, both registers and the interrupt are compared with a bench model built from the set-wins, release-then-capture and strict-priority rules.

// File: rtl/fsr_pkg.sv
`timescale 1ns/1ps
package fsr_pkg;
  localparam int NUM_EVT  = 19;
  localparam int EVT_W    = 5;
  localparam int SUB_W    = 2;
  localparam int DSYN_W   = 9;
  localparam int TSYN_W   = 4;
  localparam int WORD_W   = 64;
  localparam int FLAG_LSB = 33;
  localparam int BIT_PRIV = 52;
  localparam int BIT_ME   = 53;
  localparam int TSYN_LSB = 16;

  typedef logic [NUM_EVT-1:0] evt_vec_t;

  localparam evt_vec_t HC_SET_DEF   = 19'h0A0A9;
  localparam evt_vec_t SC_SET_DEF   = 19'h00200;
  localparam evt_vec_t DSYN_SET_DEF = 19'h033FF;
  localparam evt_vec_t TSYN_SET_DEF = 19'h0C000;

  typedef enum logic [1:0] {
    PRI_NONE = 2'd0,
    PRI_HC   = 2'd1,
    PRI_SC   = 2'd2,
    PRI_UC   = 2'd3
  } pri_e;

  function automatic logic mask_bit(evt_vec_t m, logic [EVT_W-1:0] idx);
    logic [31:0] ext;
    ext = 32'(m);
    return ext[idx];
  endfunction

  function automatic pri_e evt_pri(evt_vec_t hc, evt_vec_t sc, logic [EVT_W-1:0] idx);
    if (mask_bit(hc, idx)) return PRI_HC;
    if (mask_bit(sc, idx)) return PRI_SC;
    return PRI_UC;
  endfunction
endpackage

// File: rtl/fsr_txn_filter.sv
`timescale 1ns/1ps
module fsr_txn_filter import fsr_pkg::*; #(
  parameter int TXN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_vld_i,
  input  logic             evt_filt_i,
  input  logic [TXN_W-1:0] txn_i,
  input  logic [SUB_W-1:0] sub_i,
  output logic             log_o
);
  logic             vld_q;
  logic [TXN_W-1:0] txn_q;
  logic [SUB_W-1:0] sub_q;
  logic             drop_w;

  // later subunit of the transaction already logged
  assign drop_w = evt_filt_i && vld_q && (txn_i == txn_q) && (sub_i > sub_q);
  assign log_o  = evt_vld_i && !drop_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      txn_q <= '0;
      sub_q <= '0;
    end else if (evt_vld_i && evt_filt_i && !drop_w) begin
      vld_q <= 1'b1;
      txn_q <= txn_i;
      sub_q <= sub_i;
    end
  end

  AST_LATER_SUB_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (log_o && evt_filt_i) |=> !(log_o && evt_filt_i && txn_i == $past(txn_i) && sub_i > $past(sub_i))); // R6
endmodule

// File: rtl/fsr_flag_bank.sv
`timescale 1ns/1ps
module fsr_flag_bank import fsr_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             log_i,
  input  logic [EVT_W-1:0] typ_i,
  input  logic             hc_i,
  input  logic             priv_i,
  input  evt_vec_t         clr_flags_i,
  input  logic             clr_me_i,
  input  logic             clr_priv_i,
  output evt_vec_t         flags_o,
  output logic             me_o,
  output logic             priv_o
);
  evt_vec_t flags_q;
  evt_vec_t set_w;
  logic     me_q, priv_q, me_set_w;

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_flag
    assign set_w[g] = log_i && (typ_i == EVT_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flags_q[g] <= 1'b0;
      else         flags_q[g] <= set_w[g] | (flags_q[g] & ~clr_flags_i[g]);
    end
  end

  assign me_set_w = log_i && !hc_i && mask_bit(flags_q, typ_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      me_q   <= 1'b0;
      priv_q <= 1'b0;
    end else begin
      me_q <= me_set_w | (me_q & ~clr_me_i);
      if (log_i)           priv_q <= priv_i;
      else if (clr_priv_i) priv_q <= 1'b0;
    end
  end

  assign flags_o = flags_q;
  assign me_o    = me_q;
  assign priv_o  = priv_q;

  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    log_i |=> mask_bit(flags_q, $past(typ_i))); // R1
  AST_SET_OVER_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (log_i && mask_bit(clr_flags_i, typ_i)) |=> mask_bit(flags_q, $past(typ_i))); // R3
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_flags_i == '0) |=> (($past(flags_q) & ~flags_q) == '0)); // R2
  AST_ME_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(log_i && !hc_i) |=> !$rose(me_q)); // R4
  AST_PRIV_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    log_i |=> (priv_q == $past(priv_i))); // R5
endmodule

// File: rtl/fsr_capture_slot.sv
`timescale 1ns/1ps
module fsr_capture_slot import fsr_pkg::*; #(
  parameter int W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  pri_e             pri_i,
  input  logic [EVT_W-1:0] owner_i,
  input  logic [W-1:0]     val_i,
  input  evt_vec_t         clr_vec_i,
  output logic [W-1:0]     val_o
);
  logic [W-1:0]     val_q;
  logic             lock_q;
  logic [EVT_W-1:0] own_q;
  pri_e             pri_q;
  logic             release_w, live_w, take_w;

  assign release_w = lock_q && mask_bit(clr_vec_i, own_q);
  assign live_w    = lock_q && !release_w;
  assign take_w    = req_i && (!live_w || (pri_i > pri_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q  <= '0;
      lock_q <= 1'b0;
      own_q  <= '0;
      pri_q  <= PRI_NONE;
    end else if (take_w) begin
      val_q  <= val_i;
      lock_q <= 1'b1;
      own_q  <= owner_i;
      pri_q  <= pri_i;
    end else if (release_w) begin
      lock_q <= 1'b0;   // value kept, only freed
    end
  end

  assign val_o = val_q;

  AST_SLOT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> $stable(val_q)); // R8
  AST_NO_DEMOTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_w && req_i && (pri_i <= pri_q)) |=> ($stable(val_q) && $stable(own_q))); // R7
  AST_LOCK_ON_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> lock_q); // R7
endmodule

// File: rtl/fault_status_reg.sv
`timescale 1ns/1ps
module fault_status_reg import fsr_pkg::*; #(
  parameter int       ADDR_W   = 40,
  parameter int       TXN_W    = 4,
  parameter evt_vec_t HC_SET   = HC_SET_DEF,
  parameter evt_vec_t SC_SET   = SC_SET_DEF,
  parameter evt_vec_t DSYN_SET = DSYN_SET_DEF,
  parameter evt_vec_t TSYN_SET = TSYN_SET_DEF,
  parameter evt_vec_t IRQ_SET  = HC_SET_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_vld_i,
  input  logic [EVT_W-1:0]  evt_type_i,
  input  logic [ADDR_W-1:0] evt_addr_i,
  input  logic [DSYN_W-1:0] evt_dsyn_i,
  input  logic [TSYN_W-1:0] evt_tsyn_i,
  input  logic [TXN_W-1:0]  evt_txn_i,
  input  logic [SUB_W-1:0]  evt_sub_i,
  input  logic              evt_priv_i,
  input  logic              reg_sel_i,
  input  logic              reg_we_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o,
  input  logic              irq_en_i,
  output logic              irq_o
);
  logic              evt_ok, evt_filt, evt_log, wr_stat;
  evt_vec_t          clr_flags, flags;
  logic              clr_me, clr_priv, me, priv;
  pri_e              evt_pri_w;
  logic [ADDR_W-1:0] addr_cap;
  logic [DSYN_W-1:0] dsyn_cap;
  logic [TSYN_W-1:0] tsyn_cap;
  logic [WORD_W-1:0] stat_word;
  logic              unused_wdata;

  assign evt_ok    = evt_vld_i && (evt_type_i < EVT_W'(NUM_EVT));
  assign evt_filt  = evt_ok && mask_bit(DSYN_SET, evt_type_i);
  assign evt_pri_w = evt_pri(HC_SET, SC_SET, evt_type_i);

  assign wr_stat   = reg_we_i && !reg_sel_i;
  assign clr_flags = wr_stat ? reg_wdata_i[FLAG_LSB +: NUM_EVT] : '0;
  assign clr_me    = wr_stat && reg_wdata_i[BIT_ME];
  assign clr_priv  = wr_stat && reg_wdata_i[BIT_PRIV];
  assign unused_wdata = ^{reg_wdata_i[WORD_W-1:BIT_ME+1], reg_wdata_i[FLAG_LSB-1:0]};

  fsr_txn_filter #(.TXN_W(TXN_W)) u_filter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_vld_i  (evt_ok),
    .evt_filt_i (evt_filt),
    .txn_i      (evt_txn_i),
    .sub_i      (evt_sub_i),
    .log_o      (evt_log)
  );

  fsr_flag_bank u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .log_i       (evt_log),
    .typ_i       (evt_type_i),
    .hc_i        (mask_bit(HC_SET, evt_type_i)),
    .priv_i      (evt_priv_i),
    .clr_flags_i (clr_flags),
    .clr_me_i    (clr_me),
    .clr_priv_i  (clr_priv),
    .flags_o     (flags),
    .me_o        (me),
    .priv_o      (priv)
  );

  fsr_capture_slot #(.W(ADDR_W)) u_addr_slot (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (evt_log),
    .pri_i     (evt_pri_w),
    .owner_i   (evt_type_i),
    .val_i     (evt_addr_i),
    .clr_vec_i (clr_flags),
    .val_o     (addr_cap)
  );

  fsr_capture_slot #(.W(DSYN_W)) u_dsyn_slot (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (evt_log && mask_bit(DSYN_SET, evt_type_i)),
    .pri_i     (evt_pri_w),
    .owner_i   (evt_type_i),
    .val_i     (evt_dsyn_i),
    .clr_vec_i (clr_flags),
    .val_o     (dsyn_cap)
  );

  fsr_capture_slot #(.W(TSYN_W)) u_tsyn_slot (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (evt_log && mask_bit(TSYN_SET, evt_type_i)),
    .pri_i     (evt_pri_w),
    .owner_i   (evt_type_i),
    .val_i     (evt_tsyn_i),
    .clr_vec_i (clr_flags),
    .val_o     (tsyn_cap)
  );

  always_comb begin
    stat_word                          = '0;
    stat_word[DSYN_W-1:0]              = dsyn_cap;
    stat_word[TSYN_LSB +: TSYN_W]      = tsyn_cap;
    stat_word[FLAG_LSB +: NUM_EVT]     = flags;
    stat_word[BIT_PRIV]                = priv;
    stat_word[BIT_ME]                  = me;
  end

  assign reg_rdata_o = reg_sel_i ? WORD_W'(addr_cap) : stat_word;
  assign irq_o       = irq_en_i && |(flags & IRQ_SET);

  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |-> !irq_o); // R10
  AST_ADDR_RO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_log |=> $stable(addr_cap)); // R2
  AST_BAD_TYPE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_vld_i && !evt_ok && !reg_we_i) |=> ($stable(flags) && $stable(me))); // R1
endmodule

// File: tb/fault_status_reg_bench.sv
`timescale 1ns/1ps
module fault_status_reg_bench;
  localparam int AW = 40;
  localparam logic [31:0] B_HC = 32'h0A0A9;
  localparam logic [31:0] B_SC = 32'h00200;
  localparam logic [31:0] B_DS = 32'h033FF;
  localparam logic [31:0] B_TS = 32'h0C000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          evt_vld = 0, evt_priv = 0, reg_sel = 0, reg_we = 0, irq_en = 0;
  logic [4:0]    evt_type = '0;
  logic [AW-1:0] evt_addr = '0;
  logic [8:0]    evt_dsyn = '0;
  logic [3:0]    evt_tsyn = '0;
  logic [3:0]    evt_txn = '0;
  logic [1:0]    evt_sub = '0;
  logic [63:0]   reg_wdata = '0, rdata;
  logic          irq;

  fault_status_reg u_fault_status_reg (
    .clk_i(clk), .rst_ni(rst_n), .evt_vld_i(evt_vld), .evt_type_i(evt_type),
    .evt_addr_i(evt_addr), .evt_dsyn_i(evt_dsyn), .evt_tsyn_i(evt_tsyn),
    .evt_txn_i(evt_txn), .evt_sub_i(evt_sub), .evt_priv_i(evt_priv),
    .reg_sel_i(reg_sel), .reg_we_i(reg_we), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(rdata), .irq_en_i(irq_en), .irq_o(irq)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  bit [18:0]   m_flags = '0;
  bit          m_me = 0, m_priv = 0;
  logic [63:0] s_val [3] = '{default: '0};
  bit          s_lock [3] = '{default: 0};
  int          s_own [3] = '{default: 0};
  int          s_pri [3] = '{default: 0};
  bit          f_vld = 0;
  int          f_txn = 0, f_sub = 0;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int pri_of(int t);
    if (B_HC[t]) return 1;
    if (B_SC[t]) return 2;
    return 3;
  endfunction

  function automatic logic [63:0] exp_status();
    logic [63:0] w = '0;
    w[8:0]   = s_val[1][8:0];
    w[19:16] = s_val[2][3:0];
    w[51:33] = m_flags;
    w[52]    = m_priv;
    w[53]    = m_me;
    return w;
  endfunction

  task automatic model_clock(bit ev, int typ, logic [63:0] a, logic [63:0] ds, logic [63:0] ts,
                             int txn, int sub, bit pv, bit we, bit sel, logic [63:0] wd);
    bit valid, filt, drop, logd;
    logic [63:0] clr;
    bit [2:0] mk;
    valid = ev && (typ < 19);
    filt  = valid && B_DS[typ];
    drop  = filt && f_vld && (txn == f_txn) && (sub > f_sub);
    logd  = valid && !drop;
    clr   = (we && !sel) ? wd : 64'd0;
    if (filt && !drop) begin f_vld = 1; f_txn = txn; f_sub = sub; end
    mk = {logd && B_TS[typ], logd && B_DS[typ], logd};
    for (int k = 0; k < 3; k++) begin
      bit rel, live;
      rel  = s_lock[k] && clr[33 + s_own[k]];
      live = s_lock[k] && !rel;
      if (mk[k] && (!live || pri_of(typ) > s_pri[k])) begin
        s_val[k]  = (k == 0) ? a : (k == 1) ? ds : ts;
        s_own[k]  = typ;
        s_pri[k]  = pri_of(typ);
        s_lock[k] = 1;
      end else if (rel) s_lock[k] = 0;
    end
    m_me = (m_me && !clr[53]) || (logd && !B_HC[typ] && m_flags[typ]);
    if (logd) m_priv = pv;
    else      m_priv = m_priv && !clr[52];
    m_flags = m_flags & ~clr[51:33];
    if (logd) m_flags[typ] = 1'b1;
  endtask

  task automatic step(string req, bit ev, int typ, logic [AW-1:0] a, int txn, int sub,
                      bit pv, bit we, bit sel, logic [63:0] wd, bit ie);
    logic [8:0] ds;
    logic [3:0] ts;
    ds = a[8:0] ^ 9'h0A5;
    ts = a[3:0] ^ 4'h9;
    evt_vld = ev; evt_type = typ[4:0]; evt_addr = a; evt_dsyn = ds; evt_tsyn = ts;
    evt_txn = txn[3:0]; evt_sub = sub[1:0]; evt_priv = pv;
    reg_we = we; reg_sel = sel; reg_wdata = wd; irq_en = ie;
    @(posedge clk);
    model_clock(ev, typ, 64'(a), 64'(ds), 64'(ts), txn, sub, pv, we, sel, wd);
    #1 evt_vld = 0; reg_we = 0; reg_sel = 0;
    #1 chk(req, "status", rdata, exp_status());
    reg_sel = 1;
    #1 chk(req, "addr", rdata, {24'd0, s_val[0][AW-1:0]});
    chk(req, "irq", {63'd0, irq}, {63'd0, ie && (|(m_flags & B_HC[18:0]))});
    @(negedge clk);
  endtask

  task automatic ev(string req, int typ, logic [AW-1:0] a, int txn, int sub, bit pv);
    step(req, 1, typ, a, txn, sub, pv, 0, 0, 64'd0, 1);
  endtask

  task automatic wr(string req, bit sel, logic [63:0] wd);
    step(req, 0, 0, '0, 0, 0, 0, 1, sel, wd, 1);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    reg_sel = 0; #1 chk("R11", "reset status", rdata, 64'd0);
    reg_sel = 1; #1 chk("R11", "reset addr", rdata, 64'd0);
    chk("R11", "reset irq", {63'd0, irq}, 64'd0);
    @(negedge clk); rst_n = 1; @(negedge clk);

    // sweep of all type codes: set, repeat, clear all
    for (int t = 0; t < 22; t++) begin
      ev("R1", t, AW'(40'h10_0000_0000 + t * 40'h1040), t % 16, 0, t[0]);
      ev("R4", t, AW'(40'h20_0000_0000 + t), (t + 1) % 16, 0, 0);
      wr("R2 clear", 0, 64'hFFFF_FFFF_FFFF_FFFF);
    end

    // priority and lock
    ev("R7", 0, 40'h00_0000_1000, 1, 0, 0);
    ev("R7", 1, 40'h00_0000_2000, 2, 0, 0);
    ev("R7", 3, 40'h00_0000_3000, 3, 0, 0);
    ev("R7", 2, 40'h00_0000_4000, 4, 0, 0);
    ev("R7", 9, 40'h00_0000_5000, 5, 0, 1);
    wr("R8", 0, 64'd1 << 33);
    ev("R8", 6, 40'h00_0000_6000, 6, 0, 0);
    wr("R8", 0, 64'd1 << 34);
    ev("R8", 5, 40'h00_0000_7000, 7, 0, 0);
    ev("R8", 12, 40'h00_0000_8000, 8, 0, 0);
    wr("R2", 0, 64'hFFFF_FFFF_FFFF_FFFF);

    // collisions: set against clear, release against capture
    ev("R3", 4, 40'h00_0001_0000, 9, 0, 0);
    step("R3", 1, 4, 40'h00_0001_1000, 10, 0, 1, 1, 0, 64'd1 << 37, 1);
    step("R8", 1, 8, 40'h00_0001_2000, 11, 0, 0, 1, 0, 64'd1 << 37, 0);
    step("R3", 1, 8, 40'h00_0001_3000, 12, 0, 0, 1, 0, 64'h003F_FFFF_FFFF_FFFF, 1);
    wr("R2", 0, 64'hFFFF_FFFF_FFFF_FFFF);

    // transaction filter
    ev("R6", 0, 40'h00_0002_0000, 5, 1, 0);
    ev("R6", 1, 40'h00_0002_1000, 5, 2, 1);
    ev("R6", 0, 40'h00_0002_2000, 5, 3, 1);
    ev("R6", 10, 40'h00_0002_3000, 5, 3, 0);
    ev("R6", 1, 40'h00_0002_4000, 5, 0, 1);
    ev("R6", 2, 40'h00_0002_5000, 6, 2, 0);

    // syndromes and read-only fields
    ev("R9", 14, 40'h00_0003_0004, 0, 0, 0);
    ev("R9", 15, 40'h00_0003_0005, 0, 0, 0);
    wr("R2", 0, 64'h0000_0000_000F_01FF);
    wr("R2", 1, 64'hFFFF_FFFF_FFFF_FFFF);
    wr("R9", 0, 64'd1 << 47);
    ev("R9", 15, 40'h00_0003_0006, 0, 0, 0);
    ev("R5", 11, 40'h00_0003_0007, 0, 0, 1);
    wr("R5", 0, 64'd1 << 52);
    step("R10", 0, 0, '0, 0, 0, 0, 0, 0, 64'd0, 0);
    wr("R10", 0, 64'hFFFF_FFFF_FFFF_FFFF);

    // pseudo-random stream
    begin
      logic [31:0] x = 32'h1234_5678;
      for (int n = 0; n < 4000; n++) begin
        logic [31:0] y;
        x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
        y = x * 32'h9E37_79B9;
        step("R1 R7 R9", x[0] | x[1], int'(x[6:2]) % 22, AW'({x, y}), int'(x[8:7]),
             int'(x[10:9]), x[11], x[14:12] == 3'd0, x[15],
             {y, y & x}, x[16] | x[17]);
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule